// File: doc/BRIEF.md
# Bus Cycle Cacheability Attribute Generator

This block produces the page-level cache-disable attribute and the burst-request attribute for each processor bus cycle. At the start of a cycle it selects the cache-disable source. When paging is off, the source is the control-register cache-disable bit. When paging is on, it is one of three places, chosen by the kind of access being made: the directory base register's cache-disable bit, the directory entry's bit, or the table entry's bit. The burst-request attribute follows from that choice and from the cycle direction. Both attributes are registered when the cycle starts and stay fixed until the next cycle starts.

The system's cache-enable answer does not reach either attribute. It is sampled only in the ready phase of the cycle, on a separate strobe, to form a registered line-fill flag. The flag is set only when the cycle is a read that requested a burst. It is cleared whenever a new cycle begins. All inputs arrive already resolved. The interface is plain strobes with no back-pressure: a start strobe captures the inputs in that clock, and the bus sequencer must not start a new cycle before it has used the outputs of the current one.

Top module: `cacheattr_gen`

## Requirements
- R1: When a cycle starts with the paging-enable input low, `pcd_out` equals the cache-disable input captured at that start.
- R2: When a cycle starts with paging enabled and the cache-disable input high, `pcd_out` is 1 whatever the access kind or entry bits are.
- R3: With paging on and cache-disable low, access kinds 0 (I/O), 1 (directory entry fetch), 5 (other non-paged access), and the unused codes 6 and 7 take `pcd_out` from `dirbase_pcd`.
- R4: With paging on and cache-disable low, access kinds 2 (table entry fetch) and 3 (large-page data) take `pcd_out` from `dir_pcd`.
- R5: With paging on and cache-disable low, access kind 4 (small-page data) takes `pcd_out` from `tbl_pcd`.
- R6: `burst_out` is 1 only for a read cycle (`rd_nwr` = 1) whose access kind is not 0 and whose `pcd_out` is 0; it is never 1 while `pcd_out` is 1.
- R7: `ken` has no effect on `pcd_out` or `burst_out`.
- R8: On a `fill_stb` with no start in the same clock, `fill_ok` becomes `ken` AND the registered burst request; any `cyc_start` clears `fill_ok` and takes priority over `fill_stb`.
- R9: `pcd_out` and `burst_out` change only on a clock with `cyc_start`; after reset `pcd_out` = 1, `burst_out` = 0 and `fill_ok` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_start | input | 1 | Bus cycle start strobe; captures all attribute inputs |
| ctl_cd | input | 1 | Global cache-disable control bit |
| ctl_pg | input | 1 | Paging-enable control bit |
| dirbase_pcd | input | 1 | Cache-disable bit of the directory base register |
| dir_pcd | input | 1 | Cache-disable bit of the directory entry |
| tbl_pcd | input | 1 | Cache-disable bit of the table entry |
| acc_kind | input | 3 | Access kind code (see R3 to R5) |
| rd_nwr | input | 1 | 1 = read cycle, 0 = write cycle |
| fill_stb | input | 1 | Ready-phase strobe on which `ken` is sampled |
| ken | input | 1 | System cache-enable answer, active high |
| pcd_out | output | 1 | Registered page cache-disable attribute |
| burst_out | output | 1 | Registered burst-request attribute |
| fill_ok | output | 1 | Registered cacheable line-fill decision |

## Verification
The hardest case to reach from the ports is a ready-phase sample that meets an attribute set which has since gone stale. In that case `ken` and every selection input have changed after the start strobe, and the fill decision must still follow the captured burst request rather than the live inputs. The bench sweeps every combination of the five control bits, the eight kind codes, direction and `ken`. After each start it inverts all inputs before the ready strobe, so any leak of live inputs or of `ken` into the held attributes shows up. A start coinciding with a fill strobe is also driven directly.

// File: rtl/cacheattr_pkg.sv
package cacheattr_pkg;
  localparam int KIND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    ACC_IO    = 3'd0,
    ACC_DIR   = 3'd1,
    ACC_TBL   = 3'd2,
    ACC_BIG   = 3'd3,
    ACC_SMALL = 3'd4,
    ACC_MISC  = 3'd5
  } acc_kind_e;

  typedef enum logic [1:0] {
    SRC_CTL  = 2'd0,
    SRC_BASE = 2'd1,
    SRC_DIR  = 2'd2,
    SRC_TBL  = 2'd3
  } pcd_src_e;

  typedef struct packed {
    logic pcd;
    logic burst;
    logic rd;
  } attr_t;
endpackage

// File: rtl/pcd_select.sv
module pcd_select
  import cacheattr_pkg::*;
(
  input  logic              ctl_cd,
  input  logic              ctl_pg,
  input  logic              dirbase_pcd,
  input  logic              dir_pcd,
  input  logic              tbl_pcd,
  input  logic [KIND_W-1:0] acc_kind,
  output logic              pcd_next
);
  pcd_src_e src;

  // Source choice: global bit when paging is off or cache is disabled,
  // otherwise the structure that governs this access kind.
  always_comb begin
    if (!ctl_pg || ctl_cd) begin
      src = SRC_CTL;
    end else begin
      case (acc_kind)
        ACC_TBL, ACC_BIG: src = SRC_DIR;
        ACC_SMALL:        src = SRC_TBL;
        default:          src = SRC_BASE;
      endcase
    end
  end

  always_comb begin
    case (src)
      SRC_CTL:  pcd_next = ctl_cd;
      SRC_BASE: pcd_next = dirbase_pcd;
      SRC_DIR:  pcd_next = dir_pcd;
      default:  pcd_next = tbl_pcd;
    endcase
  end
endmodule

// File: rtl/burst_gate.sv
module burst_gate
  import cacheattr_pkg::*;
(
  input  logic              rd_nwr,
  input  logic [KIND_W-1:0] acc_kind,
  input  logic              pcd_next,
  output logic              burst_next
);
  logic is_io;
  assign is_io      = (acc_kind == ACC_IO);
  assign burst_next = rd_nwr && !is_io && !pcd_next;
endmodule

// File: rtl/attr_regs.sv
module attr_regs
  import cacheattr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_start,
  input  logic fill_stb,
  input  logic ken,
  input  attr_t attr_next,
  output attr_t attr_q,
  output logic fill_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      attr_q <= '{pcd: 1'b1, burst: 1'b0, rd: 1'b0};
    end else if (cyc_start) begin
      attr_q <= attr_next;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_q <= 1'b0;
    end else if (cyc_start) begin
      fill_q <= 1'b0;
    end else if (fill_stb) begin
      fill_q <= ken && attr_q.burst && attr_q.rd;
    end
  end
endmodule

// File: rtl/cacheattr_gen.sv
module cacheattr_gen
  import cacheattr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_start,
  input  logic              ctl_cd,
  input  logic              ctl_pg,
  input  logic              dirbase_pcd,
  input  logic              dir_pcd,
  input  logic              tbl_pcd,
  input  logic [KIND_W-1:0] acc_kind,
  input  logic              rd_nwr,
  input  logic              fill_stb,
  input  logic              ken,
  output logic              pcd_out,
  output logic              burst_out,
  output logic              fill_ok
);
  logic  pcd_next;
  logic  burst_next;
  attr_t attr_next;
  attr_t attr_q;

  pcd_select u_sel (
    .ctl_cd      (ctl_cd),
    .ctl_pg      (ctl_pg),
    .dirbase_pcd (dirbase_pcd),
    .dir_pcd     (dir_pcd),
    .tbl_pcd     (tbl_pcd),
    .acc_kind    (acc_kind),
    .pcd_next    (pcd_next)
  );

  burst_gate u_gate (
    .rd_nwr     (rd_nwr),
    .acc_kind   (acc_kind),
    .pcd_next   (pcd_next),
    .burst_next (burst_next)
  );

  assign attr_next = '{pcd: pcd_next, burst: burst_next, rd: rd_nwr};

  attr_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_start (cyc_start),
    .fill_stb  (fill_stb),
    .ken       (ken),
    .attr_next (attr_next),
    .attr_q    (attr_q),
    .fill_q    (fill_ok)
  );

  assign pcd_out   = attr_q.pcd;
  assign burst_out = attr_q.burst;
endmodule

// File: rtl/cacheattr_gen_chk.sv
module cacheattr_gen_chk
  import cacheattr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cyc_start,
  input logic              ctl_cd,
  input logic              ctl_pg,
  input logic [KIND_W-1:0] acc_kind,
  input logic              rd_nwr,
  input logic              fill_stb,
  input logic              pcd_out,
  input logic              burst_out,
  input logic              fill_ok
);
  AST_NOPAGE_FOLLOWS_CD: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && !ctl_pg) |=> (pcd_out == $past(ctl_cd))); // R1
  AST_CD_FORCES_PCD: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && ctl_cd) |=> pcd_out); // R2
  AST_BURST_EXCLUDES_PCD: assert property (@(posedge clk) disable iff (!rst_n)
    burst_out |-> !pcd_out); // R6
  AST_NO_BURST_WRITE_IO: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && (!rd_nwr || acc_kind == ACC_IO)) |=> !burst_out); // R6
  AST_FILL_NEEDS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_stb && !cyc_start && !burst_out) |=> !fill_ok); // R8
  AST_FILL_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> !fill_ok); // R8
  AST_ATTR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_start |=> ($stable(pcd_out) && $stable(burst_out))); // R9
endmodule

bind cacheattr_gen cacheattr_gen_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cyc_start (cyc_start),
  .ctl_cd    (ctl_cd),
  .ctl_pg    (ctl_pg),
  .acc_kind  (acc_kind),
  .rd_nwr    (rd_nwr),
  .fill_stb  (fill_stb),
  .pcd_out   (pcd_out),
  .burst_out (burst_out),
  .fill_ok   (fill_ok)
);

// File: tb/cacheattr_gen_test.sv
module cacheattr_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_start = 1'b0;
  logic       ctl_cd = 1'b0, ctl_pg = 1'b0;
  logic       dirbase_pcd = 1'b0, dir_pcd = 1'b0, tbl_pcd = 1'b0;
  logic [2:0] acc_kind = 3'd0;
  logic       rd_nwr = 1'b0, fill_stb = 1'b0, ken = 1'b0;
  logic       pcd_out, burst_out, fill_ok;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cacheattr_gen uut (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start),
    .ctl_cd(ctl_cd), .ctl_pg(ctl_pg), .dirbase_pcd(dirbase_pcd),
    .dir_pcd(dir_pcd), .tbl_pcd(tbl_pcd), .acc_kind(acc_kind),
    .rd_nwr(rd_nwr), .fill_stb(fill_stb), .ken(ken),
    .pcd_out(pcd_out), .burst_out(burst_out), .fill_ok(fill_ok)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model from the requirements: codes 2,3 -> directory entry,
  // 4 -> table entry, everything else -> directory base.
  function automatic logic exp_pcd(logic cd, logic pg, logic b, logic d,
                                   logic t, logic [2:0] k);
    if (!pg) return cd;
    if (cd) return 1'b1;
    if (k == 3'd2 || k == 3'd3) return d;
    if (k == 3'd4) return t;
    return b;
  endfunction

  function automatic string pcd_req(logic cd, logic pg, logic [2:0] k);
    if (!pg) return "R1";
    if (cd) return "R2";
    if (k == 3'd2 || k == 3'd3) return "R4";
    if (k == 3'd4) return "R5";
    return "R3";
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(5 * 150000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: got hung expected done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    tick();
    tick();
    // R9 reset state
    check("R9 reset pcd", pcd_out, 1'b1);
    check("R9 reset burst", burst_out, 1'b0);
    check("R9 reset fill", fill_ok, 1'b0);
    rst_n = 1'b1;

    for (int v = 0; v < 1024; v++) begin
      logic cd, pg, b, d, t, r, kn, ep, eb;
      logic [2:0] k;
      {kn, r, k, t, d, b, pg, cd} = v[9:0];
      ep = exp_pcd(cd, pg, b, d, t, k);
      eb = r && (k != 3'd0) && !ep;
      // start: ken driven to opposite of sweep value to prove no influence
      ctl_cd = cd; ctl_pg = pg; dirbase_pcd = b; dir_pcd = d; tbl_pcd = t;
      acc_kind = k; rd_nwr = r; ken = ~kn; cyc_start = 1'b1;
      tick();
      cyc_start = 1'b0;
      check(pcd_req(cd, pg, k), pcd_out, ep);
      check("R6 burst", burst_out, eb);
      check("R8 fill cleared at start", fill_ok, 1'b0);
      // invert all live inputs and ken mid-cycle
      ctl_cd = ~cd; ctl_pg = ~pg; dirbase_pcd = ~b; dir_pcd = ~d;
      tbl_pcd = ~t; acc_kind = ~k; rd_nwr = ~r; ken = kn;
      tick();
      check("R9 pcd held", pcd_out, ep);
      check("R7 burst held vs ken", burst_out, eb);
      fill_stb = 1'b1;
      tick();
      fill_stb = 1'b0;
      ken = ~kn;
      check("R8 fill decision", fill_ok, kn && eb);
      check("R7 pcd after ken", pcd_out, ep);
      tick();
      check("R8 fill holds", fill_ok, kn && eb);
    end

    // R8 start and fill strobe in the same clock: start wins
    ctl_cd = 1'b0; ctl_pg = 1'b0; acc_kind = 3'd5; rd_nwr = 1'b1; ken = 1'b1;
    cyc_start = 1'b1;
    tick();
    cyc_start = 1'b0;
    fill_stb = 1'b1;
    tick();
    fill_stb = 1'b0;
    check("R8 fill set", fill_ok, 1'b1);
    cyc_start = 1'b1; fill_stb = 1'b1;
    tick();
    cyc_start = 1'b0; fill_stb = 1'b0;
    check("R8 start beats fill", fill_ok, 1'b0);
    check("R6 burst restart", burst_out, 1'b1);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule